// File: doc/BRIEF.md
# Four-Level Address Translation Walker

This block fills the gap left by a translation-cache miss. It takes a 64-bit virtual address, works through a four-level radix page table held in memory, and returns the 52-bit physical address, a fault flag and a page-size code. The walk begins at the physical address of the top table, which is given on `root_base`. Each step reads one 8-byte entry over a simple read port whose latency can vary. The next table's location is only known once the current entry has returned, so the reads are issued one after another and never overlap.

A walk can end early. An upper-level entry with its leaf bit set maps a 1 GiB or 2 MiB region, and the walk stops there. An address whose upper bits are not a sign extension of bit 47 is rejected before any memory read. The walker serves one translation at a time.

The controller has four states. `ST_IDLE` waits for a request. `ST_ISSUE` holds a table read on the memory port. `ST_WAIT` waits for the entry to return. `ST_DONE` presents the result for one cycle. The transitions are:
- `ST_IDLE` to `ST_ISSUE` when a canonical request is accepted.
- `ST_IDLE` to `ST_DONE` when a non-canonical request is accepted.
- `ST_ISSUE` to `ST_WAIT` when the memory port accepts the read.
- `ST_WAIT` to `ST_ISSUE` when the returned entry points to another table.
- `ST_WAIT` to `ST_DONE` when the returned entry completes the walk or faults it.
- `ST_DONE` to `ST_IDLE` unconditionally.

Top module: `xlate_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: A request whose bits 63..48 are not all equal to bit 47 completes with `rsp_fault`=1 and issues no memory read.
- R3: The first read of a canonical walk goes to `{root_base[51:12], va[47:39], 3'b000}`.
- R4: Each later read goes to `{entry[51:12], va[12+9k+8 : 12+9k], 3'b000}`, where `entry` is the previous entry and k counts down from 2 to 0. Only one read is outstanding at any time.
- R5: If every entry is present (bit 0 = 1) and none of the upper three has its leaf bit (bit 7) set, the walk makes four reads. It returns `{last_entry[51:12], va[11:0]}` with size code 0 (4 KiB).
- R6: A present entry with bit 7 set in the second read ends the walk after two reads. It returns `{entry[51:30], va[29:0]}` with size code 2 (1 GiB).
- R7: A present entry with bit 7 set in the third read ends the walk after three reads. It returns `{entry[51:21], va[20:0]}` with size code 1 (2 MiB).
- R8: An entry with bit 0 = 0 at any level ends the walk with `rsp_fault`=1 and no further reads. Every faulting response reports `rsp_pa`=0 and size code 0.
- R9: A present top-level entry with bit 7 set ends the walk after one read with `rsp_fault`=1.
- R10: Bit 7 of the fourth-read entry has no effect on the result.
- R11: `req_ready` is 1 only while no walk is in progress, and a request offered during a walk is not accepted. `mem_req_valid` stays high with a stable address until `mem_req_ready` is seen.
- R12: Every accepted request produces exactly one response, signalled by `rsp_valid` high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_base | input | 52 | Physical address of the top-level table, sampled when a request is accepted |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_va | input | 64 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle pulse carrying the result |
| rsp_pa | output | 52 | Translated physical address (0 on fault) |
| rsp_fault | output | 1 | Walk failed: non-canonical, not present, or illegal leaf |
| rsp_size | output | 2 | Page size code: 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Returned table entry |

## Verification
Some properties are checked on every cycle:
- At most one table read is ever outstanding.
- A pending read request keeps its address until memory accepts it.
- The response is always a single-cycle pulse that belongs to an accepted request.
- No more than four reads occur per walk.
- A non-canonical request never reaches the memory port and always faults.
- Faulting responses carry zero address and size.

Other properties can only be shown by the bench's scenarios, because they need the page-table contents:
- The exact entry addresses.
- The early stop at 1 GiB and 2 MiB leaves.
- Rejection of a leaf at the top level.
- The indifference to the leaf bit at the last level.
- The composed physical addresses.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int VA_BITS   = 48;
    localparam int FULL_BITS = 64;
    localparam int PA_BITS   = 52;
    localparam int OFF_BITS  = 12;
    localparam int IDX_BITS  = 9;
    localparam int NUM_LVLS  = 4;
    localparam int PTE_BITS  = 64;
    localparam int PRESENT_POS = 0;
    localparam int LEAF_POS    = 7;

    typedef enum logic [1:0] {
        PG_4K = 2'd0,
        PG_2M = 2'd1,
        PG_1G = 2'd2
    } pg_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } walk_st_e;
endpackage

// File: rtl/xlate_canon.sv
// Sign-extension check of the upper virtual address bits.
module xlate_canon #(
    parameter int VA_W   = 48,
    parameter int FULL_W = 64
) (
    input  logic [FULL_W-1:0] va,
    output logic              ok
);
    localparam int TOP_W = FULL_W - VA_W + 1;

    logic [TOP_W-1:0] top_bits;

    assign top_bits = va[FULL_W-1:VA_W-1];
    assign ok       = (&top_bits) | ~(|top_bits);

    logic unused_low;
    assign unused_low = ^va[VA_W-2:0];
endmodule

// File: rtl/xlate_pte_decode.sv
// Classifies a returned entry: fault, stop (leaf reached) or descend.
module xlate_pte_decode #(
    parameter int LEVELS = 4,
    parameter int LVL_W  = 2
) (
    input  logic             present,
    input  logic             leaf,
    input  logic [LVL_W-1:0] lvl,
    output logic             fault,
    output logic             stop
);
    always_comb begin
        fault = 1'b0;
        stop  = 1'b0;
        if (!present) begin
            fault = 1'b1;
            stop  = 1'b1;
        end else if (lvl == '0) begin
            stop = 1'b1;
        end else if (leaf) begin
            stop  = 1'b1;
            fault = (lvl == LVL_W'(LEVELS - 1));
        end
    end
endmodule

// File: rtl/xlate_entry_addr.sv
// Byte address of the entry selected by the current level's index field.
module xlate_entry_addr #(
    parameter int VA_W   = 48,
    parameter int PA_W   = 52,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 9,
    parameter int LEVELS = 4,
    parameter int LVL_W  = 2
) (
    input  logic [PA_W-OFF_W-1:0] base,
    input  logic [VA_W-1:0]       va,
    input  logic [LVL_W-1:0]      lvl,
    output logic [PA_W-1:0]       addr
);
    localparam int ENT_SH = OFF_W - IDX_W;

    logic [IDX_W-1:0] idx [LEVELS];

    for (genvar k = 0; k < LEVELS; k++) begin : g_idx
        assign idx[k] = va[OFF_W + IDX_W*k +: IDX_W];
    end

    assign addr = {base, idx[lvl], {ENT_SH{1'b0}}};

    logic unused_off;
    assign unused_off = ^va[OFF_W-1:0];
endmodule

// File: rtl/xlate_leaf_addr.sv
// Physical address for a leaf at each level: entry frame bits over VA offset bits.
module xlate_leaf_addr #(
    parameter int VA_W   = 48,
    parameter int PA_W   = 52,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 9,
    parameter int LEVELS = 4,
    parameter int LVL_W  = 2,
    parameter int PTE_W  = 64
) (
    input  logic [PTE_W-1:0] pte,
    input  logic [VA_W-1:0]  va,
    input  logic [LVL_W-1:0] lvl,
    output logic [PA_W-1:0]  pa
);
    localparam int TOP_LOW = OFF_W + IDX_W*(LEVELS-1);

    logic [PA_W-1:0] cand [LEVELS];

    for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
        localparam int LOW = OFF_W + IDX_W*k;
        assign cand[k] = {pte[PA_W-1:LOW], va[LOW-1:0]};
    end

    assign pa = cand[lvl];

    logic unused_bits;
    assign unused_bits = ^{pte[PTE_W-1:PA_W], pte[OFF_W-1:0], va[VA_W-1:TOP_LOW]};
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
    import xlate_pkg::*;
#(
    parameter int VA_W   = VA_BITS,
    parameter int FULL_W = FULL_BITS,
    parameter int PA_W   = PA_BITS,
    parameter int OFF_W  = OFF_BITS,
    parameter int IDX_W  = IDX_BITS,
    parameter int LEVELS = NUM_LVLS,
    parameter int PTE_W  = PTE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PA_W-1:0]   root_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [FULL_W-1:0] req_va,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              rsp_fault,
    output logic [1:0]        rsp_size,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data
);
    localparam int LVL_W  = $clog2(LEVELS);
    localparam int BASE_W = PA_W - OFF_W;

    walk_st_e           st_q, st_d;
    logic [VA_W-1:0]    va_q;
    logic [BASE_W-1:0]  base_q;
    logic [LVL_W-1:0]   lvl_q;
    logic [PA_W-1:0]    pa_q;
    logic               fault_q;
    pg_size_e           size_q;

    logic               canon_ok;
    logic               pte_fault, pte_stop;
    logic [PA_W-1:0]    leaf_pa, entry_addr;
    logic               req_fire, rsp_fire;

    assign req_fire = (st_q == ST_IDLE) && req_valid;
    assign rsp_fire = (st_q == ST_WAIT) && mem_rsp_valid;

    xlate_canon #(.VA_W(VA_W), .FULL_W(FULL_W)) u_canon (
        .va (req_va),
        .ok (canon_ok)
    );

    xlate_pte_decode #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_dec (
        .present (mem_rsp_data[PRESENT_POS]),
        .leaf    (mem_rsp_data[LEAF_POS]),
        .lvl     (lvl_q),
        .fault   (pte_fault),
        .stop    (pte_stop)
    );

    xlate_entry_addr #(
        .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
        .LEVELS(LEVELS), .LVL_W(LVL_W)
    ) u_eaddr (
        .base (base_q),
        .va   (va_q),
        .lvl  (lvl_q),
        .addr (entry_addr)
    );

    xlate_leaf_addr #(
        .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
        .LEVELS(LEVELS), .LVL_W(LVL_W), .PTE_W(PTE_W)
    ) u_laddr (
        .pte (mem_rsp_data),
        .va  (va_q),
        .lvl (lvl_q),
        .pa  (leaf_pa)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (req_valid)     st_d = canon_ok ? ST_ISSUE : ST_DONE;
            ST_ISSUE: if (mem_req_ready) st_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) st_d = pte_stop ? ST_DONE : ST_ISSUE;
            ST_DONE:                     st_d = ST_IDLE;
            default:                     st_d = ST_IDLE;
        endcase
    end

    // Walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q    <= '0;
            base_q  <= '0;
            lvl_q   <= '0;
            pa_q    <= '0;
            fault_q <= 1'b0;
            size_q  <= PG_4K;
        end else if (req_fire) begin
            va_q    <= req_va[VA_W-1:0];
            base_q  <= root_base[PA_W-1:OFF_W];
            lvl_q   <= LVL_W'(LEVELS - 1);
            pa_q    <= '0;
            fault_q <= !canon_ok;
            size_q  <= PG_4K;
        end else if (rsp_fire) begin
            if (pte_stop) begin
                fault_q <= pte_fault;
                pa_q    <= pte_fault ? '0 : leaf_pa;
                size_q  <= pte_fault ? PG_4K : pg_size_e'(lvl_q);
            end else begin
                base_q <= mem_rsp_data[PA_W-1:OFF_W];
                lvl_q  <= lvl_q - LVL_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready     = (st_q == ST_IDLE);
        mem_req_valid = (st_q == ST_ISSUE);
        rsp_valid     = (st_q == ST_DONE);
        mem_req_addr  = entry_addr;
        rsp_pa        = pa_q;
        rsp_fault     = fault_q;
        rsp_size      = size_q;
    end
endmodule

// File: rtl/xlate_walker_chk.sv
module xlate_walker_chk #(
    parameter int VA_W   = 48,
    parameter int FULL_W = 64,
    parameter int PA_W   = 52,
    parameter int LEVELS = 4,
    parameter int PTE_W  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PA_W-1:0]   root_base,
    input logic              req_valid,
    input logic              req_ready,
    input logic [FULL_W-1:0] req_va,
    input logic              rsp_valid,
    input logic [PA_W-1:0]   rsp_pa,
    input logic              rsp_fault,
    input logic [1:0]        rsp_size,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [PA_W-1:0]   mem_req_addr,
    input logic              mem_rsp_valid,
    input logic [PTE_W-1:0]  mem_rsp_data
);
    logic       busy_q, pend_q, bad_q;
    logic [2:0] nrd_q;
    logic       va_bad;

    assign va_bad = !((&req_va[FULL_W-1:VA_W-1]) | ~(|req_va[FULL_W-1:VA_W-1]));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            pend_q <= 1'b0;
            bad_q  <= 1'b0;
            nrd_q  <= '0;
        end else begin
            if (req_valid && req_ready) begin
                busy_q <= 1'b1;
                bad_q  <= va_bad;
                nrd_q  <= '0;
            end else if (rsp_valid) begin
                busy_q <= 1'b0;
            end
            if (mem_req_valid && mem_req_ready) begin
                pend_q <= 1'b1;
                nrd_q  <= nrd_q + 3'd1;
            end else if (mem_rsp_valid) begin
                pend_q <= 1'b0;
            end
        end
    end

    a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !req_ready);
    a_r11_no_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !mem_req_valid);
    a_r11_mreq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
    a_r4_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !pend_q);
    a_r12_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    a_r12_rsp_owed: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy_q);
    a_r2_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && bad_q) |-> !mem_req_valid);
    a_r2_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && bad_q) |-> rsp_fault);
    a_r5_read_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |-> (nrd_q < 3'(LEVELS)));
    a_r6_size_code: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_size != 2'd3));
    a_r8_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_pa == '0 && rsp_size == 2'd0));

    logic unused_in;
    assign unused_in = ^{root_base, mem_rsp_data};
endmodule

bind xlate_walker xlate_walker_chk u_chk (.*);

// File: tb/sim_xlate_walker.sv
module sim_xlate_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [51:0] root_base = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_va = '0;
    logic        rsp_valid;
    logic [51:0] rsp_pa;
    logic        rsp_fault;
    logic [1:0]  rsp_size;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [51:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    always #4 clk = ~clk;   // 125 MHz

    xlate_walker u0 (.*);

    int unsigned checks = 0, fails = 0;
    logic [63:0] ent [4];
    logic [51:0] exp_addr [4];
    int          exp_n = 0, nreads = 0;
    logic [51:0] exp_pa;
    logic        exp_fault;
    logic [1:0]  exp_size;
    bit          finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit canon(input logic [63:0] va);
        return (va[63:47] == '0) || (va[63:47] == '1);
    endfunction

    task automatic predict(input logic [63:0] va, input logic [51:0] root);
        logic [39:0] base;
        logic [63:0] e;
        int          low;
        bit          done;
        exp_n = 0; exp_fault = 0; exp_pa = '0; exp_size = 2'd0;
        if (!canon(va)) begin
            exp_fault = 1;
            return;
        end
        base = root[51:12];
        done = 0;
        for (int k = 3; k >= 0; k--) begin
            if (!done) begin
                exp_addr[exp_n] = {base, 9'((va >> (12 + 9*k)) & 64'h1ff), 3'b000};
                e = ent[exp_n];
                exp_n++;
                low = 12 + 9*k;
                if (!e[0]) begin
                    exp_fault = 1; done = 1;
                end else if (k == 0) begin
                    exp_pa = {e[51:12], va[11:0]}; done = 1;
                end else if (e[7]) begin
                    if (k == 3) exp_fault = 1;
                    else begin
                        exp_pa   = (e[51:0] & ~((52'd1 << low) - 52'd1)) | (va[51:0] & ((52'd1 << low) - 52'd1));
                        exp_size = 2'(k);
                    end
                    done = 1;
                end else begin
                    base = e[51:12];
                end
            end
        end
    endtask

    // kind: 0 4K, 1 1G, 2 2M, 3 not-present at lvl np, 4 leaf at top
    task automatic mk_tables(input int kind, input int np);
        for (int i = 0; i < 4; i++) begin
            logic [63:0] e;
            e = {$urandom, $urandom};
            e[0] = 1'b1;
            e[7] = 1'b0;
            ent[i] = e;
        end
        case (kind)
            0: ent[3][7] = 1'($urandom_range(0, 1));
            1: ent[1][7] = 1'b1;
            2: ent[2][7] = 1'b1;
            3: ent[np][0] = 1'b0;
            4: ent[0][7] = 1'b1;
            default: ;
        endcase
    endtask

    // Memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_req_valid) begin
                logic [51:0] a;
                logic [63:0] d;
                repeat ($urandom_range(0, 2)) @(negedge clk);
                a = mem_req_addr;
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                if (nreads < exp_n) begin
                    chk(a == exp_addr[nreads], (nreads == 0) ? "R3 first entry address" : "R4 next entry address",
                        64'(a), 64'(exp_addr[nreads]));
                    d = ent[nreads];
                end else begin
                    chk(0, "R4 R2 R8 unexpected extra read", 64'(a), 64'd0);
                    d = '0;
                end
                nreads++;
                repeat ($urandom_range(0, 2)) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = d;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = {$urandom, $urandom};
            end
        end
    end

    task automatic do_walk(input logic [63:0] va, input logic [51:0] root, input string tag, input bit poke);
        int t;
        predict(va, root);
        nreads = 0;
        @(negedge clk);
        req_va = va; root_base = root; req_valid = 1'b1;
        chk(req_ready == 1'b1, "R11 ready while idle", 64'(req_ready), 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        if (poke && !rsp_valid) begin
            req_valid = 1'b1;
            req_va = ~va;
            chk(req_ready == 1'b0, "R11 not ready during walk", 64'(req_ready), 64'd0);
            @(negedge clk);
            req_valid = 1'b0;
        end
        t = 0;
        while (!rsp_valid && t < 400) begin
            @(negedge clk);
            t++;
        end
        chk(rsp_valid == 1'b1, "R12 response arrives", 64'(rsp_valid), 64'd1);
        chk(rsp_fault == exp_fault, {tag, " fault"}, 64'(rsp_fault), 64'(exp_fault));
        chk(rsp_pa == exp_pa, {tag, " physical address"}, 64'(rsp_pa), 64'(exp_pa));
        chk(rsp_size == exp_size, {tag, " size code"}, 64'(rsp_size), 64'(exp_size));
        chk(nreads == exp_n, {tag, " read count"}, 64'(nreads), 64'(exp_n));
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R12 single-cycle response", 64'(rsp_valid), 64'd0);
        chk(req_ready == 1'b1, "R11 ready after response", 64'(req_ready), 64'd1);
    endtask

    function automatic logic [63:0] rnd_va(input bit good);
        logic [63:0] v;
        v = {$urandom, $urandom};
        v[63:48] = {16{v[47]}};
        if (!good) v[48 + $urandom_range(0, 15)] ^= 1'b1;
        return v;
    endfunction

    function automatic logic [51:0] rnd_root();
        return {$urandom, $urandom}[51:0];
    endfunction

    initial begin
        string tags [6];
        tags[0] = "R5 R10 4K walk";
        tags[1] = "R6 1G leaf";
        tags[2] = "R7 2M leaf";
        tags[3] = "R8 not present";
        tags[4] = "R9 top leaf";
        tags[5] = "R2 non-canonical";
        void'($urandom(32'h1234_5eed));
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R1 state in reset",
            {61'd0, req_ready, rsp_valid, mem_req_valid}, 64'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R1 state after reset",
            {61'd0, req_ready, rsp_valid, mem_req_valid}, 64'b100);

        // Directed cases
        mk_tables(0, 0); ent[3][7] = 1'b0; do_walk(64'h0000_1234_5678_9abc, rnd_root(), "R5 4K walk", 1);
        mk_tables(0, 0); ent[3][7] = 1'b1; do_walk(64'hffff_8765_4321_0fed, rnd_root(), "R10 leaf bit at last level", 0);
        mk_tables(1, 0); do_walk(64'h0000_7fff_ffff_ffff, rnd_root(), "R6 1G leaf", 1);
        mk_tables(2, 0); do_walk(64'hffff_ffff_c020_1357, rnd_root(), "R7 2M leaf", 0);
        mk_tables(4, 0); do_walk(rnd_va(1), rnd_root(), "R9 top leaf", 0);
        for (int np = 0; np < 4; np++) begin
            mk_tables(3, np);
            do_walk(rnd_va(1), rnd_root(), "R8 not present", 0);
        end
        mk_tables(0, 0); do_walk(64'h8000_0000_0000_0000, rnd_root(), "R2 non-canonical top bit", 1);
        mk_tables(0, 0); do_walk(64'h0001_0000_0000_0000, rnd_root(), "R2 non-canonical bit 48", 0);
        mk_tables(0, 0); do_walk(64'hfffe_8000_0000_0000, rnd_root(), "R2 non-canonical negative", 0);

        // Constrained random
        for (int i = 0; i < 300; i++) begin
            int kind;
            kind = $urandom_range(0, 5);
            mk_tables((kind == 5) ? 0 : kind, $urandom_range(0, 3));
            do_walk(rnd_va(kind != 5), rnd_root(), tags[kind], 1'($urandom_range(0, 1)));
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R12 watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule